// File: doc/BRIEF.md
# Audio Block-Streaming DMA Controller

This controller feeds an audio output queue from main memory, one 32-byte block at a time. A periodic block tick, nominally 4 kHz, paces the transfer, because 32 bytes of 16-bit stereo samples per 4 kHz tick matches a 32 kHz sample stream. Software programs a buffer start address and a block count and then sets the enable bit. The engine walks the buffer block by block. At the end of each pass it restarts from the programmed values on its own, so the buffer plays as a ring.

Each pass start raises a one-cycle interrupt request, and so does the first enable after a fixed start delay. Software can use that request to point the shadow registers at the next buffer while the current one plays out. New values written during a pass wait in the shadow registers until the automatic reload. While the engine is disabled, every tick emits a silent (zero) block and memory is not read. Memory is reached through a simple request/acknowledge port that fetches one block per request.

Top module: `audio_dma_stream`

## Requirements
- R1: After reset all four registers read zero, the engine is disabled, and `memReq`, `outPush` and `audioIrq` are low.
- R2: Register select 0 writes and reads the upper 16 address bits. Select 1 writes and reads the lower 16 bits, and the write forces the lower 5 bits to zero.
- R3: Writing the control register (select 2) with bit 15 set while the engine is disabled enables the engine. The write latches the shadow start address as the fetch pointer and bits 14:0 of the written value as the remaining block count.
- R4: A tick while enabled with a remaining count above one requests a block at the current pointer, then advances the pointer by 32 and decrements the count.
- R5: A tick while enabled with a remaining count of one or zero requests the block at the current pointer. It then reloads the pointer and count from the shadow registers, and `audioIrq` pulses high in the cycle after the tick.
- R6: Writes to the address or control registers while the engine is enabled and stays enabled change only the shadow values. The running pass keeps its pointer and count until the next reload.
- R7: Register select 3 reads the remaining count minus one, saturating at zero, and writes to it are ignored.
- R8: After an enabling write, `audioIrq` pulses high exactly START_DELAY (default 200) clock cycles after the write's clock edge.
- R9: A `dspReset` pulse clears the whole control register, which disables the engine.
- R10: A tick while disabled gives `outPush` and `outZero` high in the next cycle, and no memory request is made.
- R11: `memReq` stays high with a stable `memAddr` until `memAck`. The cycle after the request is acknowledged carries `outPush` high with `outZero` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 address high, 1 address low, 2 control, 3 blocks left |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the selected register |
| dspReset | input | 1 | Clears the control register |
| blockTick | input | 1 | One-cycle block pacing strobe |
| memReq | output | 1 | Block read request |
| memAddr | output | 32 | Byte address of the requested block |
| memAck | input | 1 | Block read accepted |
| outPush | output | 1 | One block pushed to the output queue |
| outZero | output | 1 | The pushed block is silence |
| audioIrq | output | 1 | One-cycle audio interrupt request |

## Verification
A wrong pointer or count shows at the ports on the very next tick. `memAddr` then carries an address off the expected 32-byte walk, and the blocks-left register reads a count that does not match. A lost or mistimed reload appears one cycle after the last tick of a pass, as a missing `audioIrq` pulse or as a fetch address that does not return to the shadow start. Shadow leakage during a pass shows up in the blocks-left readback right after the write. A wrong start delay shifts the first interrupt pulse off its exact cycle.

// File: rtl/audio_dma_pkg.sv
`timescale 1ns/1ps
package audio_dma_pkg;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 16;

  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_LEFT    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic latchStart;
    logic step;
    logic reload;
    logic fetch;
  } dmaStrobe_t;
endpackage

// File: rtl/audio_dma_datapath.sv
`timescale 1ns/1ps
module audio_dma_datapath
  import audio_dma_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int BLOCK_BYTES = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [1:0]          regSel,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                dspReset,
  input  dmaStrobe_t          strobe,
  output logic [REG_W-1:0]    regRdData,
  output logic [ADDR_W-1:0]   fetchAddr,
  output logic                ctrlEn,
  output logic                remLeOne
);
  localparam int CTRL_W     = CNT_W + 1;
  localparam int ALIGN_BITS = $clog2(BLOCK_BYTES);
  localparam logic [REG_W-1:0] LOW_MASK = ~REG_W'((1 << ALIGN_BITS) - 1);

  logic [ADDR_W-1:0] startAddr;
  logic [CTRL_W-1:0] ctrlReg;
  logic [ADDR_W-1:0] curPtr;
  logic [CNT_W-1:0]  remCnt;
  logic [CNT_W-1:0]  leftView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
    end else if (regWr && regSel == SEL_ADDR_HI) begin
      startAddr[ADDR_W-1:REG_W] <= regWrData;
    end else if (regWr && regSel == SEL_ADDR_LO) begin
      startAddr[REG_W-1:0] <= regWrData & LOW_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || dspReset) begin
      ctrlReg <= '0;
    end else if (regWr && regSel == SEL_CTRL) begin
      ctrlReg <= regWrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr <= '0;
      remCnt <= '0;
    end else if (strobe.latchStart) begin
      curPtr <= startAddr;
      remCnt <= regWrData[CNT_W-1:0];
    end else if (strobe.reload) begin
      curPtr <= startAddr;
      remCnt <= ctrlReg[CNT_W-1:0];
    end else if (strobe.step) begin
      curPtr <= curPtr + ADDR_W'(BLOCK_BYTES);
      remCnt <= remCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr <= '0;
    end else if (strobe.fetch) begin
      fetchAddr <= curPtr;
    end
  end

  assign ctrlEn   = ctrlReg[CTRL_W-1];
  assign remLeOne = (remCnt <= CNT_W'(1));
  assign leftView = (remCnt == '0) ? '0 : remCnt - CNT_W'(1);

  always_comb begin
    unique case (regSel)
      SEL_ADDR_HI: regRdData = startAddr[ADDR_W-1:REG_W];
      SEL_ADDR_LO: regRdData = startAddr[REG_W-1:0];
      SEL_CTRL:    regRdData = REG_W'(ctrlReg);
      default:     regRdData = REG_W'(leftView);
    endcase
  end
endmodule

// File: rtl/audio_dma_ctrl.sv
`timescale 1ns/1ps
module audio_dma_ctrl
  import audio_dma_pkg::*;
#(
  parameter int START_DELAY = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regSel,
  input  logic             wrEnableBit,
  input  logic             dspReset,
  input  logic             blockTick,
  input  logic             ctrlEn,
  input  logic             remLeOne,
  input  logic             memAck,
  output dmaStrobe_t       strobe,
  output logic             memReq,
  output logic             outPush,
  output logic             outZero,
  output logic             audioIrq
);
  localparam int DLY_W = $clog2(START_DELAY + 1);

  logic [DLY_W-1:0] dlyCnt;
  logic             activeTick;
  logic             delayFire;

  assign activeTick        = blockTick && ctrlEn;
  assign strobe.latchStart = regWr && regSel == SEL_CTRL && wrEnableBit && !ctrlEn && !dspReset;
  assign strobe.fetch      = activeTick;
  assign strobe.reload     = activeTick && remLeOne;
  assign strobe.step       = activeTick && !remLeOne;
  assign delayFire         = ctrlEn && dlyCnt == DLY_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (strobe.latchStart) begin
      dlyCnt <= DLY_W'(START_DELAY);
    end else if (!ctrlEn) begin
      dlyCnt <= '0;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - DLY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      outPush  <= 1'b0;
      outZero  <= 1'b0;
      audioIrq <= 1'b0;
    end else begin
      if (strobe.fetch) begin
        memReq <= 1'b1;
      end else if (memAck) begin
        memReq <= 1'b0;
      end
      outPush  <= (memReq && memAck) || (blockTick && !ctrlEn);
      outZero  <= blockTick && !ctrlEn;
      audioIrq <= strobe.reload || delayFire;
    end
  end
endmodule

// File: rtl/audio_dma_stream.sv
`timescale 1ns/1ps
module audio_dma_stream
  import audio_dma_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int BLOCK_BYTES = 32,
  parameter int START_DELAY = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        dspReset,
  input  logic        blockTick,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memAck,
  output logic        outPush,
  output logic        outZero,
  output logic        audioIrq
);
  dmaStrobe_t strobe;
  logic       ctrlEn;
  logic       remLeOne;

  audio_dma_datapath #(.CNT_W(CNT_W), .BLOCK_BYTES(BLOCK_BYTES)) i_datapath (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWrData(regWrData),
    .dspReset(dspReset), .strobe(strobe), .regRdData(regRdData), .fetchAddr(memAddr),
    .ctrlEn(ctrlEn), .remLeOne(remLeOne)
  );

  audio_dma_ctrl #(.START_DELAY(START_DELAY)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .wrEnableBit(regWrData[CNT_W]),
    .dspReset(dspReset), .blockTick(blockTick), .ctrlEn(ctrlEn), .remLeOne(remLeOne),
    .memAck(memAck), .strobe(strobe), .memReq(memReq), .outPush(outPush),
    .outZero(outZero), .audioIrq(audioIrq)
  );
endmodule

// File: rtl/audio_dma_checker.sv
`timescale 1ns/1ps
module audio_dma_checker (
  input logic        clk,
  input logic        rstN,
  input logic        blockTick,
  input logic        dspReset,
  input logic        memReq,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic        outPush,
  input logic        outZero,
  input logic        audioIrq,
  input logic        ctrlEn,
  input logic        remLeOne
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !blockTick) |=> (memReq && $stable(memAddr)));

  a_r11_push_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> outPush);

  a_r10_silent_push: assert property (@(posedge clk) disable iff (!rstN)
    (blockTick && !ctrlEn) |=> (outPush && outZero && !memReq));

  a_r5_reload_irq: assert property (@(posedge clk) disable iff (!rstN)
    (blockTick && ctrlEn && remLeOne) |=> audioIrq);

  a_r9_reset_disables: assert property (@(posedge clk) disable iff (!rstN)
    dspReset |=> !ctrlEn);
endmodule

bind audio_dma_stream audio_dma_checker i_checker (
  .clk(clk), .rstN(rstN), .blockTick(blockTick), .dspReset(dspReset),
  .memReq(memReq), .memAck(memAck), .memAddr(memAddr), .outPush(outPush),
  .outZero(outZero), .audioIrq(audioIrq), .ctrlEn(ctrlEn), .remLeOne(remLeOne)
);

// File: tb/test_audio_dma_stream.sv
`timescale 1ns/1ps
module test_audio_dma_stream;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        dspReset = 1'b0;
  logic        blockTick = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic        outPush;
  logic        outZero;
  logic        audioIrq;
  logic        autoAck = 1'b1;

  int checks = 0;
  int errors = 0;

  logic [31:0] shStart = 32'd0;
  logic [15:0] shCtrl = 16'd0;
  logic [31:0] expPtr = 32'd0;
  int          expRem = 0;
  bit          expEn = 1'b0;

  audio_dma_stream i_audio_dma_stream (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .dspReset(dspReset), .blockTick(blockTick), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .outPush(outPush), .outZero(outZero),
    .audioIrq(audioIrq)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) memAck <= autoAck && memReq;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    regSel = sel;
    #1 val = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWr = 1'b0;
    case (sel)
      2'd0: shStart[31:16] = data;
      2'd1: shStart[15:0] = data & 16'hFFE0;
      2'd2: begin
        if (!expEn && data[15]) begin
          expPtr = shStart;
          expRem = int'(data[14:0]);
        end
        shCtrl = data;
        expEn = data[15];
      end
      default: ;
    endcase
  endtask

  function automatic logic [15:0] expLeft();
    return (expRem == 0) ? 16'd0 : 16'(expRem - 1);
  endfunction

  task automatic checkLeft(input string req);
    logic [15:0] v;
    readReg(2'd3, v);
    check(v == expLeft(), req, 32'(v), 32'(expLeft()));
  endtask

  task automatic doTick();
    logic [31:0] expFetch;
    bit          expIrq;
    expFetch = expPtr;
    expIrq = expEn && expRem <= 1;
    @(negedge clk);
    blockTick = 1'b1;
    @(negedge clk);
    blockTick = 1'b0;
    if (expEn) begin
      check(memReq == 1'b1, "R11 request raised", 32'(memReq), 32'd1);
      check(memAddr == expFetch, "R4 fetch address", memAddr, expFetch);
      check(audioIrq == expIrq, "R5 reload interrupt", 32'(audioIrq), 32'(expIrq));
      if (expRem <= 1) begin
        expPtr = shStart;
        expRem = int'(shCtrl[14:0]);
      end else begin
        expRem--;
        expPtr += 32;
      end
      if (autoAck) begin
        @(negedge clk);
        check(outPush && !outZero, "R11 data push", {outPush, outZero}, 32'b10);
      end
    end else begin
      check(outPush && outZero && !memReq, "R10 silent push", {memReq, outPush, outZero}, 32'b011);
      check(audioIrq == 1'b0, "R10 no interrupt", 32'(audioIrq), 32'd0);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic checkStartDelay();
    repeat (199) @(negedge clk);
    check(audioIrq == 1'b0, "R8 irq not early", 32'(audioIrq), 32'd0);
    @(negedge clk);
    check(audioIrq == 1'b1, "R8 irq at delay", 32'(audioIrq), 32'd1);
    @(negedge clk);
    check(audioIrq == 1'b0, "R8 irq one cycle", 32'(audioIrq), 32'd0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      readReg(2'(s), v);
      check(v == 16'd0, "R1 register reset", 32'(v), 32'd0);
    end
    check(!memReq && !outPush && !audioIrq, "R1 outputs idle", {memReq, outPush, audioIrq}, 32'd0);

    // R2 address halves and alignment
    writeReg(2'd0, 16'h1234);
    writeReg(2'd1, 16'hABCD);
    readReg(2'd1, v);
    check(v == 16'hABC0, "R2 low half aligned", 32'(v), 32'hABC0);
    readReg(2'd0, v);
    check(v == 16'h1234, "R2 high half", 32'(v), 32'h1234);

    // R10 disabled tick
    doTick();

    // R3 R4 R5 R7 R8 sweep over pass lengths
    for (int n = 1; n <= 4; n++) begin
      writeReg(2'd0, 16'(16'h0010 + n));
      writeReg(2'd1, 16'h0400);
      writeReg(2'd2, 16'(16'h8000 | n));
      checkStartDelay();
      checkLeft("R3 count latched");
      for (int t = 0; t < 2 * n + 1; t++) begin
        doTick();
        checkLeft("R7 blocks left");
      end
      writeReg(2'd2, 16'h0000);
    end

    // R6 shadow writes during a pass
    writeReg(2'd0, 16'h0200);
    writeReg(2'd1, 16'h0000);
    writeReg(2'd2, 16'h8003);
    checkStartDelay();
    doTick();
    writeReg(2'd0, 16'h0300);
    writeReg(2'd1, 16'h1000);
    writeReg(2'd2, 16'h8002);
    checkLeft("R6 count kept");
    check(expPtr == 32'h0200_0020, "R6 pointer model", expPtr, 32'h0200_0020);
    for (int t = 0; t < 5; t++) doTick();
    readReg(2'd2, v);
    check(v == 16'h8002, "R6 control shadow", 32'(v), 32'h8002);

    // R7 write to blocks-left ignored
    writeReg(2'd3, 16'h7FFF);
    checkLeft("R7 write ignored");
    writeReg(2'd2, 16'h0000);

    // R7 zero count saturation, reload every tick
    writeReg(2'd2, 16'h8000);
    checkStartDelay();
    checkLeft("R7 saturate zero");
    doTick();
    doTick();

    // R11 request held until acknowledge
    autoAck = 1'b0;
    doTick();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(memReq == 1'b1 && memAddr == 32'h0300_1000, "R11 request held", memAddr, 32'h0300_1000);
    end
    autoAck = 1'b1;
    begin
      bit seen = 1'b0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (outPush && !outZero) seen = 1'b1;
      end
      check(seen, "R11 push after ack", 32'(seen), 32'd1);
    end

    // R9 reset command clears control
    @(negedge clk);
    dspReset = 1'b1;
    @(negedge clk);
    dspReset = 1'b0;
    expEn = 1'b0;
    shCtrl = 16'd0;
    readReg(2'd2, v);
    check(v == 16'd0, "R9 control cleared", 32'(v), 32'd0);
    doTick();

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule